// File: doc/BRIEF.md
# Bidirectional Bus Transceiver with Parity Generator/Checker

This block joins an eight-bit bidirectional bus transceiver to a parity unit. The bus ports and the parity pin are modelled without tri-state nets. Each one is a separate input, output and drive-enable, so the whole block is synthesizable and purely combinational. A direction input picks the link mode. In transmit, data flows from port A to port B. In receive, data flows from port B to port A. A disable input, active high, releases every pin.

The parity pin serves both directions. In transmit, the block drives onto it a generated bit computed from port A. In receive, the block samples it as an incoming bit, checks it against port B, and reports the result on an active-low error pin. A select input chooses between even and odd parity.

Internally, a mode decoder reduces the control inputs to one of three named link modes:
- `LINK_OFF`: taken whenever disable is high.
- `LINK_SEND`: disable low, direction high.
- `LINK_RECV`: disable low, direction low.

The decoder has no state register. The mode follows its inputs in the same cycle, so any change of disable or direction moves at once between these modes. A steering unit then enables the pins that act as outputs in that mode.

Top module: `bus_xcvr_parity`

## Requirements
- R1: In transmit (`dir_tx`=1, `dis`=0), `b_drv` is 1, `b_out` equals `a_in`, and `a_drv` is 0.
- R2: In receive (`dir_tx`=0, `dis`=0), `a_drv` is 1, `a_out` equals `b_in`, and `b_drv` is 0.
- R3: With `dis`=1, `a_drv`, `b_drv`, `par_drv` and `err_drv` are all 0, whatever the other inputs are.
- R4: Each data output (`a_out`, `b_out`, `par_out`, `err_n_out`) reads all zeros while its drive-enable is 0.
- R5: In transmit, `par_drv` is 1. With `odd_sel`=0 (even), `par_out` is 1 exactly when `a_in` holds an odd number of ones. With `odd_sel`=1 (odd), `par_out` is the inverse of that.
- R6: In receive, the parity pin is an input (`par_drv`=0) and the error pin is driven (`err_drv`=1).
- R7: In receive, `err_n_out` is 1 when the number of ones in `b_in` plus `par_in` is even under `odd_sel`=0, or odd under `odd_sel`=1. Otherwise `err_n_out` is 0.
- R8: In transmit, `err_drv` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | WIDTH | Value sensed on port A |
| a_out | output | WIDTH | Value driven onto port A |
| a_drv | output | 1 | Drive-enable for port A |
| b_in | input | WIDTH | Value sensed on port B |
| b_out | output | WIDTH | Value driven onto port B |
| b_drv | output | 1 | Drive-enable for port B |
| par_in | input | 1 | Value sensed on the parity pin |
| par_out | output | 1 | Generated parity bit |
| par_drv | output | 1 | Drive-enable for the parity pin |
| err_n_out | output | 1 | Check result: 1 = good, 0 = parity error |
| err_drv | output | 1 | Drive-enable for the error pin |
| dir_tx | input | 1 | 1 = transmit (A to B), 0 = receive (B to A) |
| dis | input | 1 | 1 = release all pins |
| odd_sel | input | 1 | 0 = even parity, 1 = odd parity |

## Verification
The block has no register on any path, so every result is due in the same cycle as the stimulus that causes it. The bench changes inputs just after a rising clock edge and compares all outputs at the following falling edge, once everything has settled. The expected values come from a behavioural model that counts ones with an integer loop. A sweep covers every data value, both directions, both parity selects, both incoming parity values and both disable levels. Port A and port B carry different values throughout the sweep, so a swap between them is visible.

// File: rtl/xcvr_par_pkg.sv
package xcvr_par_pkg;
    typedef enum logic [1:0] {
        LINK_OFF  = 2'd0,
        LINK_SEND = 2'd1,
        LINK_RECV = 2'd2
    } link_mode_e;
endpackage

// File: rtl/xcvr_mode_dec.sv
module xcvr_mode_dec
    import xcvr_par_pkg::*;
(
    input  logic       dis,
    input  logic       dir_tx,
    output link_mode_e mode
);
    always_comb begin
        if (dis)         mode = LINK_OFF;
        else if (dir_tx) mode = LINK_SEND;
        else             mode = LINK_RECV;
    end

    // R3: a disabled link never reports an active mode
    always_comb begin
        if (dis) assert_off_when_disabled_R3: assert (mode == LINK_OFF);
    end
endmodule

// File: rtl/xcvr_parity_core.sv
module xcvr_parity_core #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] gen_word,
    input  logic [WIDTH-1:0] chk_word,
    input  logic             chk_bit,
    input  logic             odd_sel,
    output logic             gen_bit,
    output logic             chk_ok
);
    logic gen_xor;
    logic chk_xor;

    always_comb begin
        gen_xor = ^gen_word;
        chk_xor = (^chk_word) ^ chk_bit;
        gen_bit = gen_xor ^ odd_sel;
        chk_ok  = (chk_xor == odd_sel);
    end
endmodule

// File: rtl/xcvr_port_steer.sv
module xcvr_port_steer
    import xcvr_par_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  link_mode_e       mode,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             gen_bit,
    input  logic             chk_ok,
    output logic [WIDTH-1:0] a_out,
    output logic             a_drv,
    output logic [WIDTH-1:0] b_out,
    output logic             b_drv,
    output logic             par_out,
    output logic             par_drv,
    output logic             err_n_out,
    output logic             err_drv
);
    localparam logic [WIDTH-1:0] ZERO_W = '0;

    always_comb begin
        a_out     = ZERO_W;
        a_drv     = 1'b0;
        b_out     = ZERO_W;
        b_drv     = 1'b0;
        par_out   = 1'b0;
        par_drv   = 1'b0;
        err_n_out = 1'b0;
        err_drv   = 1'b0;
        unique case (mode)
            LINK_SEND: begin
                b_out   = a_in;
                b_drv   = 1'b1;
                par_out = gen_bit;
                par_drv = 1'b1;
            end
            LINK_RECV: begin
                a_out     = b_in;
                a_drv     = 1'b1;
                err_n_out = chk_ok;
                err_drv   = 1'b1;
            end
            default: begin
                a_drv = 1'b0;
            end
        endcase
    end

    // R1/R2: the two ports are never driven together
    always_comb begin
        assert_one_port_driven_R1: assert (!(a_drv && b_drv));
    end
    // R8: the error pin and the parity output never drive together
    always_comb begin
        assert_err_idle_in_send_R8: assert (!(par_drv && err_drv));
    end
endmodule

// File: rtl/bus_xcvr_parity.sv
module bus_xcvr_parity
    import xcvr_par_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_drv,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_drv,
    input  logic             par_in,
    output logic             par_out,
    output logic             par_drv,
    output logic             err_n_out,
    output logic             err_drv,
    input  logic             dir_tx,
    input  logic             dis,
    input  logic             odd_sel
);
    link_mode_e mode;
    logic       gen_bit;
    logic       chk_ok;

    xcvr_mode_dec u_mode (
        .dis    (dis),
        .dir_tx (dir_tx),
        .mode   (mode)
    );

    xcvr_parity_core #(.WIDTH(WIDTH)) u_par (
        .gen_word (a_in),
        .chk_word (b_in),
        .chk_bit  (par_in),
        .odd_sel  (odd_sel),
        .gen_bit  (gen_bit),
        .chk_ok   (chk_ok)
    );

    xcvr_port_steer #(.WIDTH(WIDTH)) u_steer (
        .mode      (mode),
        .a_in      (a_in),
        .b_in      (b_in),
        .gen_bit   (gen_bit),
        .chk_ok    (chk_ok),
        .a_out     (a_out),
        .a_drv     (a_drv),
        .b_out     (b_out),
        .b_drv     (b_drv),
        .par_out   (par_out),
        .par_drv   (par_drv),
        .err_n_out (err_n_out),
        .err_drv   (err_drv)
    );

    // R3: disable releases every pin
    always_comb begin
        if (dis) assert_all_released_R3: assert (!a_drv && !b_drv && !par_drv && !err_drv);
    end
    // R5: A plus the driven parity bit meets the selected parity
    always_comb begin
        if (par_drv) assert_gen_meets_sel_R5: assert ((^{a_in, par_out}) == odd_sel);
    end
    // R7: driven error flag agrees with the parity of B plus the incoming bit
    always_comb begin
        if (err_drv) assert_check_matches_R7: assert (err_n_out == ((^{b_in, par_in}) == odd_sel));
    end
    // R8: no error drive while transmitting
    always_comb begin
        if (dir_tx) assert_err_hiz_tx_R8: assert (!err_drv);
    end
endmodule

// File: tb/bus_xcvr_parity_tb.sv
module bus_xcvr_parity_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic         par_in = 1'b0, dir_tx = 1'b0, dis = 1'b1, odd_sel = 1'b0;
    logic [W-1:0] a_out, b_out;
    logic         a_drv, b_drv, par_out, par_drv, err_n_out, err_drv;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    bus_xcvr_parity #(.WIDTH(W)) u_dut (
        .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
        .b_in(b_in), .b_out(b_out), .b_drv(b_drv),
        .par_in(par_in), .par_out(par_out), .par_drv(par_drv),
        .err_n_out(err_n_out), .err_drv(err_drv),
        .dir_tx(dir_tx), .dis(dis), .odd_sel(odd_sel)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h (a=%0h b=%0h dir=%0b dis=%0b sel=%0b pin=%0b)",
                     req, act, exp, a_in, b_in, dir_tx, dis, odd_sel, par_in);
        end
    endtask

    function automatic int ones(input logic [W-1:0] v);
        int n = 0;
        for (int i = 0; i < W; i++) if (v[i]) n++;
        return n;
    endfunction

    task automatic compare_all();
        bit send = !dis && dir_tx;
        bit recv = !dis && !dir_tx;
        logic exp_par;
        logic exp_err;
        exp_par = ((ones(a_in) % 2) == 1) ^ odd_sel;
        exp_err = (((ones(b_in) + (par_in ? 1 : 0)) % 2) == (odd_sel ? 1 : 0));
        if (dis) begin
            check("R3 a_drv", a_drv, 0);
            check("R3 b_drv", b_drv, 0);
            check("R3 par_drv", par_drv, 0);
            check("R3 err_drv", err_drv, 0);
        end
        if (send) begin
            check("R1 b_drv", b_drv, 1);
            check("R1 a_drv", a_drv, 0);
            check("R1 b_out", b_out, b_in ^ b_in ^ a_in);
            check("R5 par_drv", par_drv, 1);
            check("R5 par_out", par_out, exp_par);
            check("R8 err_drv", err_drv, 0);
        end
        if (recv) begin
            check("R2 a_drv", a_drv, 1);
            check("R2 b_drv", b_drv, 0);
            check("R2 a_out", a_out, b_in);
            check("R6 par_drv", par_drv, 0);
            check("R6 err_drv", err_drv, 1);
            check("R7 err_n_out", err_n_out, exp_err);
        end
        if (!a_drv)   check("R4 a_out idle", a_out, 0);
        if (!b_drv)   check("R4 b_out idle", b_out, 0);
        if (!par_drv) check("R4 par_out idle", par_out, 0);
        if (!err_drv) check("R4 err_n_out idle", err_n_out, 0);
    endtask

    task automatic apply(input logic [W-1:0] d, input bit dr, input bit ds,
                         input bit sel, input bit pin);
        @(posedge clk);
        #1;
        a_in    = d;
        b_in    = {d[3:0], d[7:4]} ^ 8'h5A;
        dir_tx  = dr;
        dis     = ds;
        odd_sel = sel;
        par_in  = pin;
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // reset state: disabled at start, every pin released (R3)
        check("R3 reset a_drv", a_drv, 0);
        check("R3 reset b_drv", b_drv, 0);
        check("R3 reset par_drv", par_drv, 0);
        check("R3 reset err_drv", err_drv, 0);
        rst = 1'b0;
        // R7 worked example: even select, even count on B, incoming bit high
        @(posedge clk); #1;
        dis = 1'b0; dir_tx = 1'b0; odd_sel = 1'b0; par_in = 1'b1; b_in = 8'h03; a_in = 8'h00;
        @(negedge clk);
        check("R7 example err_n_out", err_n_out, 0);
        // R5 corner: all ones under both selects
        apply(8'hFF, 1'b1, 1'b0, 1'b0, 1'b0);
        apply(8'hFF, 1'b1, 1'b0, 1'b1, 1'b1);
        // full sweep
        for (int d = 0; d < 256; d++)
            for (int m = 0; m < 16; m++)
                apply(d[7:0], m[0], m[1], m[2], m[3]);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule